// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small byte queue of instruction stream ahead of an execution-side consumer. A bus-side fetch port asks memory for aligned 16-bit words. Each returned word is written into the queue. At the same time the consumer takes bytes from the head, one per cycle, so the two sides overlap and fetching can run ahead of consumption.

A fetch is requested only when the queue has room for a whole word. When a control transfer occurs, the consumer raises a redirect with a target address. The queue is emptied at once and fetching restarts at the target. The consumer sees the queue empty until the first new word lands, which is the refill penalty of a taken branch. A word that returns in the same cycle as a redirect is thrown away. When the target address is odd, only the upper byte of the first word is kept.

Top module: `pfq_top`

## Requirements
- R1: Out of reset the queue is empty (popValid low, qEmpty high), fetchReq is high and fetchAddr equals the RESET_ADDR parameter (default 0).
- R2: The queue holds at most DEPTH bytes (default 6). fetchReq is high exactly when the occupancy is DEPTH-2 or less, so at occupancy 5 or 6 the bus side stays idle.
- R3: A word is accepted on a cycle where fetchReq and fetchAck are both high and redirect is low. Its bits [7:0] (the byte at fetchAddr) enter the queue before bits [15:8] (the byte at fetchAddr+1). Bytes leave in arrival order, and the head byte stays unchanged while it is not popped.
- R4: fetchAddr is always even and advances by 2, modulo 2^16, after each accepted word.
- R5: A pop takes effect only when popReq is high and popValid is high. A pop request while the queue is empty changes nothing. popValid is high exactly when the occupancy is non-zero, and qEmpty is its inverse.
- R6: When a word is accepted and a byte is popped in the same cycle, the occupancy changes by the number of bytes pushed minus one.
- R7: A redirect empties the queue by the next cycle and sets fetchAddr to the target with bit 0 cleared. Any pop in that cycle is ignored.
- R8: When fetchAck is high in a redirect cycle, the returned word is dropped and no byte of it is queued.
- R9: After a redirect to an odd target, the first accepted word queues only its bits [15:8]. Later words queue both bytes.
- R10: Byte order is kept across the wrap of the circular storage for any mix of push and pop timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | output | 1 | Word fetch request, held until acknowledged or redirected |
| fetchAddr | output | 16 | Even byte address of the requested word |
| fetchAck | input | 1 | Memory returns fetchData this cycle |
| fetchData | input | 16 | Returned word, lower address in bits [7:0] |
| popReq | input | 1 | Consumer takes the head byte |
| popData | output | 8 | Head byte of the queue |
| popValid | output | 1 | Head byte is valid |
| qEmpty | output | 1 | Queue holds no byte |
| redirect | input | 1 | Flush and restart fetching at redirectAddr |
| redirectAddr | input | 16 | Byte address of the new stream |

## Verification
The embedded properties check, on every cycle, that the occupancy never goes past capacity and that a full queue requests nothing. They also check the step of the fetch address after each accepted word, that the queue is empty and the address realigned right after a redirect, and that the head byte holds while nothing pops it. Only the bench scenarios can show the byte stream end to end. These cover the order of bytes across the storage wrap, the dropping of a word acknowledged in a redirect cycle, the single upper byte after an odd target, and the effect of pop requests on an empty queue. The bench sweeps memory latency, consumer pop pattern and target alignment, and predicts every byte from its address.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Strobes that the control issues to the byte storage each cycle.
  typedef struct packed {
    logic flush;     // drop all bytes, pointers back to slot 0
    logic popEn;     // head byte leaves
    logic pushPair;  // both bytes of the incoming word enter
    logic pushHigh;  // only the upper byte of the incoming word enters
  } pfqStrobe_t;

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH      = 6,
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchAck,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirectAddr,
  input  logic              popReq,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              popValid,
  output pfqStrobe_t        strobe
);

  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int WORD_ROOM = 2;
  localparam logic [CNT_W-1:0] REQ_LIMIT = CNT_W'(DEPTH - WORD_ROOM);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_ROOM);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  countNext;
  logic [ADDR_W-1:0] addrQ;
  logic              oddPending;
  logic              accept;
  logic [1:0]        pushN;

  // Request only from registered occupancy: a word fits whenever asked.
  assign fetchReq  = (count <= REQ_LIMIT);
  assign fetchAddr = addrQ;
  assign popValid  = (count != '0);
  assign accept    = fetchReq & fetchAck & ~redirect;

  assign strobe.flush    = redirect;
  assign strobe.popEn    = popReq & popValid & ~redirect;
  assign strobe.pushPair = accept & ~oddPending;
  assign strobe.pushHigh = accept & oddPending;

  always_comb begin
    pushN = 2'd0;
    if (strobe.pushPair)      pushN = 2'd2;
    else if (strobe.pushHigh) pushN = 2'd1;
    countNext = count + CNT_W'(pushN) - CNT_W'(strobe.popEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      addrQ      <= RESET_ADDR & EVEN_MASK;
      oddPending <= RESET_ADDR[0];
    end else if (redirect) begin
      count      <= '0;
      addrQ      <= redirectAddr & EVEN_MASK;
      oddPending <= redirectAddr[0];
    end else begin
      count <= countNext;
      if (accept) begin
        addrQ      <= addrQ + ADDR_STEP;
        oddPending <= 1'b0;
      end
    end
  end

  // R2: storage never overfills
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2: a full queue leaves the bus idle
  assert_full_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) |-> !fetchReq);

  // R4: word address steps by one word per accepted fetch
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> fetchAddr == $past(fetchAddr) + ADDR_STEP);

  // R7, R8: redirect leaves an empty queue pointed at the aligned target
  assert_redirect_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (!popValid && fetchAddr == ($past(redirectAddr) & EVEN_MASK)));

endmodule

// File: rtl/pfq_data.sv
module pfq_data
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pfqStrobe_t          strobe,
  input  logic [2*BYTE_W-1:0] wordIn,
  output logic [BYTE_W-1:0]   popData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  wrPtrPlus1;
  logic [BYTE_W-1:0] slotView [DEPTH];
  logic [BYTE_W-1:0] lowByte;
  logic [BYTE_W-1:0] highByte;

  // Circular increment for a depth that need not be a power of two.
  function automatic logic [PTR_W-1:0] ptrAdd(input logic [PTR_W-1:0] p,
                                              input logic [1:0] step);
    logic [PTR_W+1:0] s;
    s = {2'b00, p} + {{PTR_W{1'b0}}, step};
    if (s >= (PTR_W+2)'(DEPTH)) s = s - (PTR_W+2)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  assign lowByte    = wordIn[BYTE_W-1:0];
  assign highByte   = wordIn[2*BYTE_W-1:BYTE_W];
  assign wrPtrPlus1 = ptrAdd(wrPtr, 2'd1);

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [BYTE_W-1:0] byteQ;
    logic              hitFirst;
    logic              hitSecond;
    assign hitFirst  = (wrPtr == PTR_W'(i));
    assign hitSecond = (wrPtrPlus1 == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (!strobe.flush) begin
        if (strobe.pushPair && hitFirst)       byteQ <= lowByte;
        else if (strobe.pushPair && hitSecond) byteQ <= highByte;
        else if (strobe.pushHigh && hitFirst)  byteQ <= highByte;
      end
    end
    assign slotView[i] = byteQ;
  end

  assign popData = slotView[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strobe.popEn)         rdPtr <= ptrAdd(rdPtr, 2'd1);
      if (strobe.pushPair)      wrPtr <= ptrAdd(wrPtr, 2'd2);
      else if (strobe.pushHigh) wrPtr <= wrPtrPlus1;
    end
  end

  // R10: both pointers stay inside the storage across every wrap
  assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr < PTR_W'(DEPTH)) && (wrPtr < PTR_W'(DEPTH)));

  // R7: after a flush reading and writing restart at the same slot
  assert_flush_align_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (rdPtr == wrPtr));

endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
  parameter int DEPTH      = 6,
  parameter int ADDR_W     = 16,
  parameter int BYTE_W     = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                clk,
  input  logic                rstN,
  output logic                fetchReq,
  output logic [ADDR_W-1:0]   fetchAddr,
  input  logic                fetchAck,
  input  logic [2*BYTE_W-1:0] fetchData,
  input  logic                popReq,
  output logic [BYTE_W-1:0]   popData,
  output logic                popValid,
  output logic                qEmpty,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   redirectAddr
);

  pfq_pkg::pfqStrobe_t strobe;

  pfq_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .fetchAck(fetchAck), .redirect(redirect),
    .redirectAddr(redirectAddr), .popReq(popReq), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .popValid(popValid), .strobe(strobe)
  );

  pfq_data #(
    .DEPTH(DEPTH), .BYTE_W(BYTE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(fetchData), .popData(popData)
  );

  assign qEmpty = ~popValid;

  // R3, R5: an unpopped head byte stays put
  assert_hold_head_R3: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReq && !redirect) |=> (popValid && $stable(popData)));

  // R7: the empty status follows a redirect
  assert_empty_after_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> qEmpty);

endmodule

// File: tb/sim_pfq_top.sv
module sim_pfq_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic [15:0] fetchData = '0;
  logic        popReq = 1'b0;
  logic [7:0]  popData;
  logic        popValid;
  logic        qEmpty;
  logic        redirect = 1'b0;
  logic [15:0] redirectAddr = '0;

  int totalChecks = 0;
  int badChecks   = 0;
  bit finished    = 0;

  // Reference model state, built from the requirements alone.
  int          occ = 0;
  logic [15:0] expFetch = '0;
  logic [15:0] expPop = '0;
  bit          firstOdd = 0;
  int          waitCnt = 0;
  int          cycleNo = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfq_top u0 (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchAck(fetchAck), .fetchData(fetchData), .popReq(popReq),
    .popData(popData), .popValid(popValid), .qEmpty(qEmpty),
    .redirect(redirect), .redirectAddr(redirectAddr)
  );

  function automatic logic [7:0] byteAt(input logic [15:0] a);
    return (a[7:0] ^ 8'h3C) ^ a[15:8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycleNo);
    end
  endtask

  // One cycle: observe at the falling edge, then drive for the next rising edge.
  task automatic step(input int lat, input int popMode, input bit doRedirect,
                      input logic [15:0] tgt);
    bit doPop;
    bit ack;
    @(negedge clk);
    cycleNo++;
    chk(popValid == (occ != 0), "R5", "popValid", int'(popValid), int'(occ != 0));
    chk(qEmpty == (occ == 0), "R5", "qEmpty", int'(qEmpty), int'(occ == 0));
    chk(fetchReq == (occ <= DEPTH - 2), "R2", "fetchReq", int'(fetchReq), int'(occ <= DEPTH - 2));
    chk(fetchAddr == expFetch, "R4", "fetchAddr", int'(fetchAddr), int'(expFetch));

    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (popMode)
      0:       doPop = 1'b1;
      1:       doPop = cycleNo[0];
      2:       doPop = lfsr[0];
      default: doPop = 1'b0;
    endcase
    doPop = doPop && (occ != 0);
    if (doPop) begin
      chk(popData == byteAt(expPop), "R3 R10", "popData", int'(popData), int'(byteAt(expPop)));
      expPop = expPop + 16'd1;
    end
    // Mode 0 keeps requesting on an empty queue too (R5 ignored pops).
    popReq = doPop || (popMode == 0);

    ack = (occ <= DEPTH - 2) && (doRedirect || waitCnt >= lat);
    fetchAck     = ack;
    fetchData    = {byteAt(expFetch + 16'd1), byteAt(expFetch)};
    redirect     = doRedirect;
    redirectAddr = tgt;

    if (doRedirect) begin
      // R7, R8: flush, word acknowledged now is lost
      occ      = 0;
      expFetch = tgt & 16'hFFFE;
      firstOdd = tgt[0];
      expPop   = tgt;
      waitCnt  = 0;
    end else begin
      if (ack) begin
        occ      = occ + (firstOdd ? 1 : 2);  // R9 single upper byte
        expFetch = expFetch + 16'd2;
        firstOdd = 0;
        waitCnt  = 0;
      end else if (occ <= DEPTH - 2) begin
        waitCnt++;
      end
      if (doPop) occ = occ - 1;  // R6 combined update
    end
  endtask

  task automatic phase(input int lat, input int popMode, input logic [15:0] tgt,
                       input int cycles);
    step(lat, popMode, 1'b1, tgt);
    for (int k = 0; k < cycles; k++) step(lat, popMode, 1'b0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(popValid == 1'b0, "R1", "popValid", int'(popValid), 0);
    chk(qEmpty == 1'b1, "R1", "qEmpty", int'(qEmpty), 1);
    chk(fetchReq == 1'b1, "R1", "fetchReq", int'(fetchReq), 1);
    chk(fetchAddr == 16'h0000, "R1", "fetchAddr", int'(fetchAddr), 0);

    // Stream straight out of reset, random pops.
    for (int k = 0; k < 40; k++) step(1, 2, 1'b0, 16'h0000);

    // Sweep: memory latency x pop pattern x target alignment (R2..R10).
    for (int lat = 0; lat < 3; lat++)
      for (int mode = 0; mode < 4; mode++)
        for (int odd = 0; odd < 2; odd++)
          phase(lat, mode, 16'h1200 + 16'(lat * 64 + mode * 16 + odd), 45);

    // Address wrap at the top of the space (R4) with an odd target (R9).
    phase(0, 0, 16'hFFF9, 30);
    phase(2, 1, 16'hFFFC, 30);

    // Back-to-back redirects, the first word is dropped (R8).
    step(0, 0, 1'b1, 16'h4000);
    step(0, 0, 1'b1, 16'h5003);
    for (int k = 0; k < 30; k++) step(0, 2, 1'b0, 16'h0000);

    // Fill then drain to see the storage wrap many times (R10).
    phase(0, 3, 16'h0777, 12);
    for (int k = 0; k < 60; k++) step(0, 1, 1'b0, 16'h0000);

    @(negedge clk);
    fetchAck = 1'b0;
    popReq   = 1'b0;
    redirect = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      totalChecks++;
      badChecks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

endmodule